// File: doc/BRIEF.md
# Per-Flow Linked-List Packet Queue Manager

This block keeps an independent first-in first-out queue for each of a small number of flows. All queues share a single pool of packet slots. Each slot holds one 32-bit word together with its start-of-packet and end-of-packet marks, plus a link to the next slot. Every flow always owns one spare slot at its tail. An arriving word is written into that spare slot. A fresh slot is then taken from the pool of unused slots and linked behind it as the new spare, so an arrival never has to look back at older entries. A departure reads the word at the flow's head and moves the head along the stored link. The freed slot goes back to the pool.

The pool of unused slots is a ring of slot numbers. After reset, ring entry i holds slot number i. The first FLOWS slots are handed out as the initial spare slots of the flows. A flow is empty when its head and tail point to the same slot, so the shared capacity is DEPTH minus FLOWS words.

A global transmit-enable input halts all departures without losing data, and arrivals continue while it is low. Arrivals and departure requests share the same cycle budget. When both are presented in one cycle, only the arrival is performed.

Top module: `qm_flow_queues`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `in_full` is 0, and every flow is empty.
- R2: Words dequeued from one flow leave in the order they were accepted for that flow. `out_data`, `out_sop` and `out_eop` equal the stored values, and `out_flow` equals the requested flow.
- R3: A departure performed at a clock edge raises `out_valid` for exactly the following cycle. Departures may be requested on consecutive cycles, and each one yields its own output cycle.
- R4: Flows are independent: interleaved arrivals to different flows do not change the contents or order of any other flow.
- R5: A departure request for an empty flow is ignored: no `out_valid` follows and no state changes.
- R6: While `tx_enable` is 0, no departure takes place and `out_valid` stays 0, while arrivals are still accepted. After `tx_enable` returns to 1, the held words leave unchanged and in order.
- R7: With default parameters (DEPTH=16, FLOWS=4), the shared capacity is 12 words. `in_full` is 1 exactly when 12 words are held. An arrival offered while `in_full` is 1 is dropped and never appears at the output.
- R8: Slots freed by departures are reused. After all queues drain, the full capacity of 12 words can be accepted again.
- R9: If `in_valid` and `deq_req` are both 1 in a cycle, only the arrival is performed. `out_valid` is 0 in the next cycle, and the departure takes place once it is requested again without a concurrent arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Arrival strobe for one word |
| in_flow | input | FLOW_W | Flow number of the arrival |
| in_data | input | 32 | Arriving data word |
| in_sop | input | 1 | Start-of-packet mark of the arriving word |
| in_eop | input | 1 | End-of-packet mark of the arriving word |
| in_full | output | 1 | No unused slot left; arrivals are dropped |
| deq_req | input | 1 | Departure request |
| deq_flow | input | FLOW_W | Flow number to depart from |
| tx_enable | input | 1 | 1 allows departures, 0 holds every queue |
| out_valid | output | 1 | Output word valid (registered) |
| out_flow | output | FLOW_W | Flow the output word came from |
| out_data | output | 32 | Departing data word |
| out_sop | output | 1 | Start-of-packet mark of the departing word |
| out_eop | output | 1 | End-of-packet mark of the departing word |

## Verification
The properties assume that `tx_enable`, `in_valid` and `deq_req` are held stable across each rising edge. They also assume that `deq_flow` and `in_flow` name existing flows. The bench therefore changes every input only on the falling edge and uses flow numbers 0 to 3 only. The slot-count bound also assumes that the environment never frees more slots than it took. This holds because only the block returns slots, and the stimulus reaches the full and empty extremes repeatedly without ever offering an impossible departure.

// File: rtl/qm_pkg.sv
package qm_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } qm_word_t;

    function automatic qm_word_t make_word(input logic s, input logic e,
                                           input logic [WORD_W-1:0] d);
        qm_word_t w;
        w.sop  = s;
        w.eop  = e;
        w.data = d;
        return w;
    endfunction
endpackage

// File: rtl/qm_free_ring.sv
module qm_free_ring #(
    parameter int DEPTH = 16,
    parameter int RESV  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    output logic [PTR_W-1:0] pop_ptr,
    input  logic             push,
    input  logic [PTR_W-1:0] push_ptr,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [PTR_W-1:0] ring [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wr_idx;

    assign wr_idx  = rd_q + cnt_q[PTR_W-1:0];
    assign pop_ptr = ring[rd_q];
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ring[i] <= PTR_W'(i);
            end
            rd_q  <= PTR_W'(RESV);
            cnt_q <= CNT_W'(DEPTH - RESV);
        end else begin
            if (push) begin
                ring[wr_idx] <= push_ptr;
            end
            if (pop) begin
                rd_q <= rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/qm_slot_store.sv
module qm_slot_store
    import qm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  qm_word_t         wr_word,
    input  logic [PTR_W-1:0] wr_link,
    input  logic [PTR_W-1:0] rd_addr,
    output qm_word_t         rd_word,
    output logic [PTR_W-1:0] rd_link
);
    qm_word_t         words [DEPTH];
    logic [PTR_W-1:0] links [DEPTH];

    assign rd_word = words[rd_addr];
    assign rd_link = links[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_word;
            links[wr_addr] <= wr_link;
        end
    end
endmodule

// File: rtl/qm_flow_table.sv
module qm_flow_table #(
    parameter int FLOWS = 4,
    parameter int DEPTH = 16,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int FLOW_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_en,
    input  logic [FLOW_W-1:0] enq_flow,
    input  logic [PTR_W-1:0]  enq_new_tail,
    output logic [PTR_W-1:0]  enq_tail,
    input  logic              deq_en,
    input  logic [FLOW_W-1:0] deq_flow,
    input  logic [PTR_W-1:0]  deq_new_head,
    output logic [PTR_W-1:0]  deq_head,
    output logic              deq_empty
);
    logic [PTR_W-1:0] head_q [FLOWS];
    logic [PTR_W-1:0] tail_q [FLOWS];

    assign enq_tail  = tail_q[enq_flow];
    assign deq_head  = head_q[deq_flow];
    assign deq_empty = (head_q[deq_flow] == tail_q[deq_flow]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < FLOWS; f++) begin
                head_q[f] <= PTR_W'(f);
                tail_q[f] <= PTR_W'(f);
            end
        end else begin
            if (enq_en) begin
                tail_q[enq_flow] <= enq_new_tail;
            end
            if (deq_en) begin
                head_q[deq_flow] <= deq_new_head;
            end
        end
    end
endmodule

// File: rtl/qm_flow_queues.sv
module qm_flow_queues
    import qm_pkg::*;
#(
    parameter int FLOWS = 4,
    parameter int DEPTH = 16,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1,
    localparam int FLOW_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              in_full,
    input  logic              deq_req,
    input  logic [FLOW_W-1:0] deq_flow,
    input  logic              tx_enable,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_flow,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);
    logic             enq_go, deq_go;
    logic             ring_empty;
    logic [CNT_W-1:0] free_cnt;
    logic [PTR_W-1:0] fresh_ptr, tail_ptr, head_ptr, head_link;
    logic             flow_empty;
    qm_word_t         head_word;

    assign in_full = ring_empty;
    assign enq_go  = in_valid && !ring_empty;
    assign deq_go  = deq_req && !in_valid && tx_enable && !flow_empty;

    qm_free_ring #(.DEPTH(DEPTH), .RESV(FLOWS)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .pop      (enq_go),
        .pop_ptr  (fresh_ptr),
        .push     (deq_go),
        .push_ptr (head_ptr),
        .empty    (ring_empty),
        .count    (free_cnt)
    );

    qm_flow_table #(.FLOWS(FLOWS), .DEPTH(DEPTH)) u_table (
        .clk          (clk),
        .rst          (rst),
        .enq_en       (enq_go),
        .enq_flow     (in_flow),
        .enq_new_tail (fresh_ptr),
        .enq_tail     (tail_ptr),
        .deq_en       (deq_go),
        .deq_flow     (deq_flow),
        .deq_new_head (head_link),
        .deq_head     (head_ptr),
        .deq_empty    (flow_empty)
    );

    qm_slot_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (enq_go),
        .wr_addr (tail_ptr),
        .wr_word (make_word(in_sop, in_eop, in_data)),
        .wr_link (fresh_ptr),
        .rd_addr (head_ptr),
        .rd_word (head_word),
        .rd_link (head_link)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flow  <= '0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= deq_go;
            if (deq_go) begin
                out_flow <= deq_flow;
                out_data <= head_word.data;
                out_sop  <= head_word.sop;
                out_eop  <= head_word.eop;
            end
        end
    end
endmodule

// File: rtl/qm_flow_queues_chk.sv
module qm_flow_queues_chk #(
    parameter int CAP   = 12,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_full,
    input logic             deq_req,
    input logic             tx_enable,
    input logic             out_valid,
    input logic [CNT_W-1:0] free_cnt
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_out_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
        !deq_req |=> !out_valid);

    assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !out_valid);

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (in_full && in_valid) |=> $stable(free_cnt));

    assert_slot_bound_R8: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= CAP[CNT_W-1:0]);

    assert_arrival_first_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && deq_req) |=> !out_valid);
endmodule

bind qm_flow_queues qm_flow_queues_chk #(.CAP(DEPTH - FLOWS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_full   (in_full),
    .deq_req   (deq_req),
    .tx_enable (tx_enable),
    .out_valid (out_valid),
    .free_cnt  (free_cnt)
);

// File: tb/qm_flow_queues_bench.sv
module qm_flow_queues_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NF  = 4;
    localparam int DEP = 16;
    localparam int CAP = DEP - NF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_flow = '0;
    logic [31:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_full;
    logic        deq_req = 1'b0;
    logic [1:0]  deq_flow = '0;
    logic        tx_enable = 1'b1;
    logic        out_valid;
    logic [1:0]  out_flow;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int checks = 0;
    int errors = 0;
    int held   = 0;

    logic [33:0] model_q [NF][$];
    logic [35:0] exp_w [$];
    string       exp_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qm_flow_queues #(.FLOWS(NF), .DEPTH(DEP)) u_qm_flow_queues (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_flow(in_flow), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_full(in_full),
        .deq_req(deq_req), .deq_flow(deq_flow), .tx_enable(tx_enable),
        .out_valid(out_valid), .out_flow(out_flow), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_enq(input int f, input logic [31:0] d, input logic s,
                          input logic e, input string tag);
        bit acc;
        @(negedge clk);
        in_valid = 1'b1; in_flow = 2'(f); in_data = d; in_sop = s; in_eop = e;
        deq_req = 1'b0;
        acc = (held < CAP);
        check(in_full == !acc, tag, "in_full before arrival", 64'(in_full), 64'(!acc));
        @(posedge clk);
        if (acc) begin
            model_q[f].push_back({s, e, d});
            held++;
        end
    endtask

    task automatic do_deq(input int f, input string tag);
        bit fire;
        logic [33:0] w;
        @(negedge clk);
        in_valid = 1'b0; deq_req = 1'b1; deq_flow = 2'(f);
        fire = tx_enable && (model_q[f].size() > 0);
        @(posedge clk);
        if (fire) begin
            w = model_q[f].pop_front();
            held--;
            exp_w.push_back({2'(f), w});
            exp_tag.push_back(tag);
        end
    endtask

    task automatic do_both(input int fe, input logic [31:0] d, input int fd,
                           input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_flow = 2'(fe); in_data = d; in_sop = 1'b1; in_eop = 1'b1;
        deq_req = 1'b1; deq_flow = 2'(fd);
        @(posedge clk);
        if (held < CAP) begin
            model_q[fe].push_back({1'b1, 1'b1, d});
            held++;
        end
    endtask

    task automatic expect_quiet(input string tag);
        @(negedge clk);
        in_valid = 1'b0; deq_req = 1'b0;
        check(out_valid == 1'b0, tag, "out_valid after ignored request", 64'(out_valid), 64'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; deq_req = 1'b0;
        end
    endtask

    task automatic drain_all(input string tag);
        for (int f = 0; f < NF; f++) begin
            while (model_q[f].size() > 0) do_deq(f, tag);
        end
    endtask

    // Monitor: compares each output cycle against the scoreboard
    logic [35:0] mon_w;
    string       mon_t;
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_w.size() > 0) begin
                mon_w = exp_w.pop_front();
                mon_t = exp_tag.pop_front();
                check(out_valid == 1'b1, mon_t, "out_valid", 64'(out_valid), 64'd1);
                check({out_flow, out_sop, out_eop, out_data} == mon_w, mon_t,
                      "flow/sop/eop/data", 64'({out_flow, out_sop, out_eop, out_data}),
                      64'(mon_w));
            end else if (out_valid) begin
                check(1'b0, "R3", "unexpected out_valid", 64'd1, 64'd0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog run did not complete actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_full == 1'b0, "R1", "in_full after reset", 64'(in_full), 64'd0);

        // R1, R5: every flow starts empty, so departures are ignored
        for (int f = 0; f < NF; f++) begin
            do_deq(f, "R5");
            expect_quiet("R5");
        end

        // R2, R4: interleaved arrivals, then ordered departures
        do_enq(0, 32'hA000_0001, 1'b1, 1'b0, "R4");
        do_enq(2, 32'hB000_0001, 1'b1, 1'b1, "R4");
        do_enq(0, 32'hA000_0002, 1'b0, 1'b0, "R4");
        do_enq(2, 32'hB000_0002, 1'b1, 1'b0, "R4");
        do_enq(0, 32'hA000_0003, 1'b0, 1'b1, "R4");
        do_deq(2, "R2");
        do_deq(0, "R2");
        do_deq(0, "R3");
        do_deq(2, "R3");
        do_deq(0, "R3");
        do_deq(0, "R5");
        expect_quiet("R5");

        // R6: departures held while transmit is disabled
        @(negedge clk); tx_enable = 1'b0;
        do_enq(1, 32'hC000_0001, 1'b1, 1'b0, "R6");
        do_deq(1, "R6");
        expect_quiet("R6");
        do_enq(1, 32'hC000_0002, 1'b0, 1'b1, "R6");
        do_deq(1, "R6");
        expect_quiet("R6");
        @(negedge clk); tx_enable = 1'b1;
        do_deq(1, "R6");
        do_deq(1, "R6");
        idle(2);

        // R7: fill all shared slots, then a dropped arrival
        for (int i = 0; i < CAP; i++) begin
            do_enq(i % NF, 32'hD000_0000 + 32'(i), 1'b1, 1'b1, "R7");
        end
        idle(1);
        check(in_full == 1'b1, "R7", "in_full at capacity", 64'(in_full), 64'd1);
        do_enq(3, 32'hDEAD_BEEF, 1'b1, 1'b1, "R7");
        drain_all("R7");
        do_deq(3, "R7");
        expect_quiet("R7");
        check(in_full == 1'b0, "R8", "in_full after drain", 64'(in_full), 64'd0);

        // R8: recycled slots give back the full capacity
        for (int i = 0; i < CAP; i++) begin
            do_enq((i * 3) % NF, 32'hE000_0000 + 32'(i), i[0], !i[0], "R8");
        end
        idle(1);
        check(in_full == 1'b1, "R8", "in_full after refill", 64'(in_full), 64'd1);
        for (int k = 0; k < CAP / NF; k++) begin
            for (int f = NF - 1; f >= 0; f--) do_deq(f, "R8");
        end
        drain_all("R8");

        // R9: arrival wins over a same-cycle departure
        do_enq(3, 32'hF000_0001, 1'b1, 1'b0, "R9");
        do_both(3, 32'hF000_0002, 3, "R9");
        expect_quiet("R9");
        do_deq(3, "R9");
        do_deq(3, "R9");
        idle(3);
        check(exp_w.size() == 0, "R2", "outstanding expected outputs",
              64'(exp_w.size()), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule